// File: doc/BRIEF.md
# Infrared SIR Receive Pulse Stretcher

This block sits between the receive output of a serial infrared transceiver and the receive line of a UART. The transceiver marks each zero bit with a short active-low pulse, typically around 2 us wide and never much shorter than about 1.63 us. The block turns each such pulse into a low level that lasts exactly one bit period at the programmed rate, giving the UART an ordinary NRZ stream that idles high. The width of the incoming pulse plays no part in the output width: the bit period is timed only from a 16x baud tick that the rate generator supplies.

The raw input is asynchronous. It passes through a synchroniser, and only its falling edge starts a stretch. A second falling edge during a running stretch restarts the bit timer, so consecutive zero bits merge into one continuous low. An active-low activity indicator mirrors the decoded data. While the transmitter is sending, the transceiver's own receiver can echo the outgoing light; an enable input (driven from a programmable output bit, default on) blanks newly detected edges while transmit data is active. While the device is in rate-programming mode, the receive path is forced idle.

Top module: `sir_rx_stretch`

## Requirements
- R1: While reset is asserted and directly after it, rx_nrz and rx_led_n are both high.
- R2: A falling edge on ir_rx_n, applied just after a clock edge, drives rx_nrz low after the third following rising clock edge (two synchroniser flops, then the timer flop), and not earlier.
- R3: Once started, rx_nrz stays low for exactly TICKS_PER_BIT (default 16) cycles in which tick16 is high, and goes high on the edge that samples the last of those ticks.
- R4: Holding ir_rx_n low for longer than a bit period gives the same output as a short pulse: rx_nrz returns high while the input is still low, and no further stretch begins until a new falling edge.
- R5: A falling edge accepted while a stretch runs restarts the count, so the low lasts the ticks already counted plus a full TICKS_PER_BIT ticks.
- R6: rx_led_n equals rx_nrz on every cycle (low while decoded data is low).
- R7: With echo_blank_en high, a falling edge detected while tx_active is high is discarded; the input staying low after tx_active drops does not start a stretch.
- R8: With echo_blank_en low, falling edges are accepted regardless of tx_active.
- R9: While prog_mode is high, falling edges are discarded, and a running stretch ends on the next clock edge with rx_nrz high.
- R10: A tick16 pulse sampled on the same edge that accepts a falling edge is not counted toward the bit period.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| ir_rx_n | input | 1 | Asynchronous active-low pulse from the infrared receiver |
| tx_active | input | 1 | High while transmit data is being sent |
| echo_blank_en | input | 1 | High enables blanking of the receive input during transmit |
| prog_mode | input | 1 | High while the device is in rate-programming mode |
| rx_nrz | output | 1 | Stretched NRZ receive data, idles high |
| rx_led_n | output | 1 | Active-low receive activity indicator |

## Verification
Single short pulses are sent with ticks every cycle, every second cycle and every third cycle; counting ticks during each low rather than cycles separates a correct bit timer from one off by a tick, and the every-cycle pattern also exposes a tick wrongly counted on the accepting edge. A pulse held low across the whole bit shows whether the output follows the input width, and a second pulse ten ticks into a stretch shows whether the timer restarts or simply ignores it. Pulses under transmit with blanking on and off, a held-low input that outlives the blanking window, and programming mode both before and during a stretch tell apart the gating rules.

// File: rtl/sir_rx_pkg.sv
package sir_rx_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_STRETCH = 1'b1
  } stretch_e;

  // Counter width able to hold values 0 .. ticks-1.
  function automatic int cnt_bits(input int ticks);
    return (ticks < 2) ? 1 : $clog2(ticks);
  endfunction

  // Index of the final tick of one bit period.
  function automatic int last_tick(input int ticks);
    return ticks - 1;
  endfunction

endpackage

// File: rtl/sir_rx_sync.sv
module sir_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/sir_rx_edge_gate.sv
module sir_rx_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  input  logic prog_mode,
  input  logic tx_active,
  input  logic blank_en,
  output logic fall_evt,
  output logic accept_evt
);

  logic prev_level;
  logic echo_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_level <= 1'b1;
    else        prev_level <= level_n;
  end

  assign fall_evt   = prev_level & ~level_n;
  assign echo_block = blank_en & tx_active;
  assign accept_evt = fall_evt & ~prog_mode & ~echo_block;

endmodule

// File: rtl/sir_rx_bit_timer.sv
module sir_rx_bit_timer
  import sir_rx_pkg::*;
#(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic active
);

  localparam int CW   = cnt_bits(TICKS);
  localparam int LAST = last_tick(TICKS);

  stretch_e        state;
  logic [CW-1:0]   cnt;
  logic            at_last;
  logic            finish;

  assign at_last = (cnt == CW'(LAST));
  assign finish  = (state == ST_STRETCH) && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= ST_STRETCH;
      cnt   <= '0;
    end else if (finish) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if ((state == ST_STRETCH) && tick) begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign active = (state == ST_STRETCH);

endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
  parameter int SYNC_STAGES   = 2,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_rx_n,
  input  logic tx_active,
  input  logic echo_blank_en,
  input  logic prog_mode,
  output logic rx_nrz,
  output logic rx_led_n
);

  logic ir_sync_n;
  logic fall_evt;
  logic accept_evt;
  logic stretch_active;

  sir_rx_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(ir_rx_n),
    .q_sync (ir_sync_n)
  );

  sir_rx_edge_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_n   (ir_sync_n),
    .prog_mode (prog_mode),
    .tx_active (tx_active),
    .blank_en  (echo_blank_en),
    .fall_evt  (fall_evt),
    .accept_evt(accept_evt)
  );

  sir_rx_bit_timer #(
    .TICKS(TICKS_PER_BIT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept_evt),
    .abort (prog_mode),
    .tick  (tick16),
    .active(stretch_active)
  );

  assign rx_nrz   = ~stretch_active;
  assign rx_led_n = rx_nrz;

endmodule

// File: rtl/sir_rx_stretch_chk.sv
module sir_rx_stretch_chk #(
  parameter int TICKS_PER_BIT = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic tx_active,
  input logic echo_blank_en,
  input logic prog_mode,
  input logic rx_nrz,
  input logic rx_led_n,
  input logic fall_evt,
  input logic accept_evt
);

  localparam int KW = $clog2(TICKS_PER_BIT + 2) + 1;

  // Independent tally of ticks seen while the output is low.
  logic [KW-1:0] low_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     low_ticks <= '0;
    else if (accept_evt)                            low_ticks <= '0;
    else if (!rx_nrz && tick16 && !(&low_ticks))    low_ticks <= low_ticks + 1'b1;
  end

  assert_led_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_led_n == rx_nrz);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !rx_nrz);

  assert_prog_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |=> rx_nrz);

  assert_echo_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && echo_blank_en && tx_active && rx_nrz) |=> rx_nrz);

  assert_bit_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_nrz) && !$past(prog_mode)) |-> (low_ticks == KW'(TICKS_PER_BIT)));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nrz |-> (low_ticks < KW'(TICKS_PER_BIT)));

endmodule

bind sir_rx_stretch sir_rx_stretch_chk #(
  .TICKS_PER_BIT(TICKS_PER_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick16       (tick16),
  .tx_active    (tx_active),
  .echo_blank_en(echo_blank_en),
  .prog_mode    (prog_mode),
  .rx_nrz       (rx_nrz),
  .rx_led_n     (rx_led_n),
  .fall_evt     (fall_evt),
  .accept_evt   (accept_evt)
);

// File: tb/sir_rx_stretch_tb.sv
module sir_rx_stretch_tb;

  localparam int TPB = 16;

  logic clk = 1'b0;
  logic rst_n, tick16, ir_rx_n, tx_active, echo_blank_en, prog_mode;
  logic rx_nrz, rx_led_n;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  sir_rx_stretch #(.SYNC_STAGES(2), .TICKS_PER_BIT(TPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_rx_n(ir_rx_n),
    .tx_active(tx_active), .echo_blank_en(echo_blank_en),
    .prog_mode(prog_mode), .rx_nrz(rx_nrz), .rx_led_n(rx_led_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One cycle: inputs held, then step to 1 ns after the next rising edge.
  task automatic step(input bit tk);
    tick16 = tk;
    @(posedge clk);
    #1;
    tick16 = 1'b0;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 0; g < gap; g++) step(1'b0);
    end
  endtask

  // Drive a falling edge and advance to just past the edge that would accept it.
  task automatic pulse_start(input int hold, input bit tk);
    ir_rx_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i == hold) ir_rx_n = 1'b1;
      step(tk);
    end
  endtask

  // Monitor: tally ticks during each low period, compare with the scoreboard.
  bit mon_prev = 1'b1;
  int mon_cnt  = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_led_n !== rx_nrz) begin
        n_checks++; n_fail++;
        $display("FAIL R6 led actual=%0d expected=%0d", rx_led_n, rx_nrz);
      end
      if (rx_nrz === 1'b0) begin
        if (mon_prev) mon_cnt = 0;
        if (tick16) mon_cnt++;
      end else if (!mon_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected low period", mon_cnt, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(mon_cnt == e, "R3 ticks in low period", mon_cnt, e);
        end
      end
      mon_prev = rx_nrz;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ir_rx_n = 1'b1; tick16 = 1'b0; tx_active = 1'b0;
    echo_blank_en = 1'b1; prog_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(rx_nrz == 1'b1 && rx_led_n == 1'b1, "R1 reset", {rx_nrz, rx_led_n}, 3);
    rst_n = 1'b1;
    step(1'b0);
    chk(rx_nrz == 1'b1 && rx_led_n == 1'b1, "R1 after reset", {rx_nrz, rx_led_n}, 3);

    // R2 latency, R3 with ticks every third cycle
    exp_q.push_back(TPB);
    ir_rx_n = 1'b0;
    step(1'b0);
    step(1'b0);
    chk(rx_nrz == 1'b1, "R2 not before third edge", rx_nrz, 1);
    ir_rx_n = 1'b1;
    step(1'b0);
    chk(rx_nrz == 1'b0, "R2 low after third edge", rx_nrz, 0);
    run_ticks(TPB, 2);
    step(1'b0);
    chk(rx_nrz == 1'b1, "R3 high after bit", rx_nrz, 1);
    step(1'b0);

    // R10: ticks every cycle, including the accepting edge
    exp_q.push_back(TPB);
    pulse_start(2, 1'b1);
    run_ticks(TPB, 0);
    step(1'b0);
    chk(rx_nrz == 1'b1, "R10 high after bit", rx_nrz, 1);

    // R4: long incoming pulse
    exp_q.push_back(TPB);
    pulse_start(100, 1'b0);
    run_ticks(TPB, 1);
    step(1'b0);
    chk(rx_nrz == 1'b1 && ir_rx_n == 1'b0, "R4 high while input low", rx_nrz, 1);
    run_ticks(20, 0);
    chk(rx_nrz == 1'b1, "R4 no second stretch", rx_nrz, 1);
    ir_rx_n = 1'b1;
    repeat (3) step(1'b0);

    // R5: restart ten ticks into a stretch
    exp_q.push_back(TPB + 10);
    pulse_start(2, 1'b0);
    run_ticks(10, 0);
    pulse_start(2, 1'b0);
    chk(rx_nrz == 1'b0, "R5 still low at restart", rx_nrz, 0);
    run_ticks(TPB - 1, 0);
    chk(rx_nrz == 1'b0, "R5 low one tick before end", rx_nrz, 0);
    run_ticks(1, 0);
    step(1'b0);
    chk(rx_nrz == 1'b1, "R5 high after restart bit", rx_nrz, 1);

    // R7: echo blanking
    tx_active = 1'b1;
    pulse_start(2, 1'b0);
    repeat (4) step(1'b1);
    chk(rx_nrz == 1'b1, "R7 blanked pulse", rx_nrz, 1);
    pulse_start(50, 1'b0);
    step(1'b0);
    tx_active = 1'b0;
    repeat (6) step(1'b1);
    chk(rx_nrz == 1'b1, "R7 held-low input after blank", rx_nrz, 1);
    ir_rx_n = 1'b1;
    repeat (3) step(1'b0);

    // R8: blanking disabled
    echo_blank_en = 1'b0;
    tx_active = 1'b1;
    exp_q.push_back(TPB);
    pulse_start(2, 1'b0);
    chk(rx_nrz == 1'b0, "R8 accepted during transmit", rx_nrz, 0);
    run_ticks(TPB, 1);
    step(1'b0);
    tx_active = 1'b0;
    echo_blank_en = 1'b1;
    step(1'b0);

    // R9: programming mode
    prog_mode = 1'b1;
    pulse_start(2, 1'b0);
    repeat (3) step(1'b1);
    chk(rx_nrz == 1'b1, "R9 ignored in programming", rx_nrz, 1);
    prog_mode = 1'b0;
    step(1'b0);
    exp_q.push_back(5);
    pulse_start(2, 1'b0);
    run_ticks(5, 0);
    prog_mode = 1'b1;
    step(1'b0);
    chk(rx_nrz == 1'b1, "R9 stretch aborted", rx_nrz, 1);
    prog_mode = 1'b0;
    repeat (4) step(1'b0);

    chk(exp_q.size() == 0, "R3 all expected periods seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule